// File: doc/BRIEF.md
# Speed-Selectable Data-Strobe Serial Transmitter

This block turns parallel words from a link-layer controller into a data-strobe serial pair. One fast clock runs at eight times the system clock. A free-running phase counter marks a word boundary once every eight fast cycles, and that boundary stands for the system-clock edge. At each boundary the block captures 2, 4 or 8 bits of the transmit word. How many depends on the latched speed code. It then shifts those bits out most significant first, one bit every 4, 2 or 1 fast cycles, so that every captured word takes exactly one word period.

Each serial bit goes out on the data output. The strobe output changes only when a bit repeats the one before it, so exactly one of the two lines changes per bit. A receiver can rebuild the bit clock from data XOR strobe. Three inputs together decide whether transmission is allowed: the transmit request, the port-ready flag and the power-down flag. While transmission is not allowed, both lines sit at 0 and the encoder history is cleared. The speed code is taken only at an idle boundary, so a word in flight can never change its rate.

Top module: `ds_tx_encoder`

## Requirements
- R1: The speed code selects how many low bits of `tx_data` are sent: 2'b00 sends `tx_data[1:0]`, 2'b01 sends `tx_data[3:0]`, 2'b10 sends `tx_data[7:0]`, and the reserved code 2'b11 behaves as 2'b00. Bits above the selected field have no effect on the outputs.
- R2: `word_load_o` is high for one fast cycle out of every eight. The first of these is the first cycle after reset. The value on `tx_data` during that cycle is the word captured at the edge that closes it.
- R3: Captured bits appear most significant first. The first bit is on `data_o` in the cycle after the capture edge. Later bits follow every 4 (2'b00), 2 (2'b01) or 1 (2'b10) fast cycles, and the outputs hold steady between bit updates.
- R4: For each bit sent, the strobe toggles if and only if the new data bit equals the previous one, so data XOR strobe changes on every bit.
- R5: Transmission is allowed only when `tx_en` is 1, `port_ok` is 1 and `pwr_down` is 0. In any cycle where it is not allowed, `data_o` and `strobe_o` are 0 in that same cycle.
- R6: Any cycle in which transmission is not allowed resets the encoder history, so the previous data and strobe both count as 0. This holds even when the previous word stopped after an odd number of bits.
- R7: Back-to-back words with transmission allowed continuously carry the encoder history across the word boundary.
- R8: The speed code is latched only at a word boundary where transmission is not allowed. A change of `speed_i` while transmitting has no effect on the width or rate of later words.
- R9: If transmission becomes allowed in the middle of a word period, the outputs stay 0 until the next word boundary captures a new word.
- R10: While `rst` is high, both outputs are 0. After reset the phase restarts, so `word_load_o` is high in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, eight times the system rate |
| rst | input | 1 | Synchronous active-high reset |
| speed_i | input | 2 | Requested speed code |
| tx_en | input | 1 | Transmit request from the link layer |
| port_ok | input | 1 | Port enabled, connected and not suspended |
| pwr_down | input | 1 | Power-down request; blocks transmission |
| tx_data | input | 8 | Parallel transmit word |
| word_load_o | output | 1 | High in the fast cycle whose closing edge captures `tx_data` |
| data_o | output | 1 | Encoded serial data line |
| strobe_o | output | 1 | Encoded serial strobe line |

## Verification
The history reset in R6 is the hardest case to observe. Every full word has an even number of bits, so data XOR strobe is back at 0 after any complete word, and a missing reset would not show. The stimulus therefore stops an 8-bit word after its first bit. It then sends a 2-bit word of two ones, whose strobe pattern differs depending on whether the history was cleared. The speed-latch and mid-word-enable cases are driven the same way: inputs change at chosen phases counted from the `word_load_o` pulse.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

    typedef enum logic [1:0] {
        SPD_S100 = 2'b00,
        SPD_S200 = 2'b01,
        SPD_S400 = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    typedef struct packed {
        logic valid;
        logic value;
    } ser_bit_t;

    typedef struct packed {
        logic dat;
        logic stb;
    } ds_pair_t;

    // log2 of the bit period in fast cycles; also log2 of word narrowing
    function automatic logic [1:0] speed_shift(speed_e s);
        case (s)
            SPD_S400: return 2'd0;
            SPD_S200: return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/ds_tx_timebase.sv
module ds_tx_timebase
    import ds_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  speed_e spd,
    output logic   word_start,
    output logic   bit_ce
);
    localparam int PH_W = $clog2(W);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst)
            ph <= '0;
        else if (ph == PH_W'(W - 1))
            ph <= '0;
        else
            ph <= ph + 1'b1;
    end

    always_comb begin
        mask       = PH_W'((1 << speed_shift(spd)) - 1);
        word_start = (ph == '0);
        bit_ce     = ((ph & mask) == '0);
    end

endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
    import ds_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         word_start,
    input  logic         bit_ce,
    input  speed_e       spd,
    input  logic [W-1:0] word_i,
    output ser_bit_t     bit_o
);
    logic [W-1:0] shreg;
    logic [W-1:0] aligned;
    logic         running;
    logic         load;
    logic         shift;
    int           nbits;

    always_comb begin
        nbits   = W >> speed_shift(spd);
        aligned = word_i << (W - nbits);
        load    = active && word_start;
        shift   = active && running && bit_ce && !word_start;
        bit_o.valid = load || shift;
        bit_o.value = load ? aligned[W-1] : shreg[W-1];
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            shreg   <= '0;
            running <= 1'b0;
        end else if (load) begin
            shreg   <= aligned << 1;
            running <= 1'b1;
        end else if (shift) begin
            shreg   <= shreg << 1;
        end
    end

endmodule

// File: rtl/ds_tx_strobe.sv
module ds_tx_strobe
    import ds_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  ser_bit_t bit_i,
    output ds_pair_t pair_o
);
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pair_o <= '0;
        end else if (bit_i.valid) begin
            pair_o.dat <= bit_i.value;
            pair_o.stb <= pair_o.stb ^ (bit_i.value ~^ pair_o.dat);
        end
    end

endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
    import ds_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   speed_i,
    input  logic         tx_en,
    input  logic         port_ok,
    input  logic         pwr_down,
    input  logic [W-1:0] tx_data,
    output logic         word_load_o,
    output logic         data_o,
    output logic         strobe_o
);
    logic     tx_active;
    logic     word_start;
    logic     bit_ce;
    speed_e   spd_q;
    ser_bit_t ser_bit;
    ds_pair_t pair_q;

    assign tx_active = tx_en && port_ok && !pwr_down;

    always_ff @(posedge clk) begin
        if (rst)
            spd_q <= SPD_S100;
        else if (word_start && !tx_active)
            spd_q <= speed_e'(speed_i);
    end

    ds_tx_timebase #(.W(W)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .spd        (spd_q),
        .word_start (word_start),
        .bit_ce     (bit_ce)
    );

    ds_tx_serializer #(.W(W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .active     (tx_active),
        .word_start (word_start),
        .bit_ce     (bit_ce),
        .spd        (spd_q),
        .word_i     (tx_data),
        .bit_o      (ser_bit)
    );

    ds_tx_strobe u_stb (
        .clk    (clk),
        .rst    (rst),
        .active (tx_active),
        .bit_i  (ser_bit),
        .pair_o (pair_q)
    );

    assign word_load_o = word_start;
    assign data_o      = pair_q.dat & tx_active;
    assign strobe_o    = pair_q.stb & tx_active;

endmodule

// File: rtl/ds_tx_encoder_chk.sv
module ds_tx_encoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       active,
    input logic       word_load,
    input logic       bit_valid,
    input logic       data_o,
    input logic       strobe_o,
    input logic [1:0] spd_q,
    input logic       hist_d,
    input logic       hist_s
);
    assert_word_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        word_load |=> !word_load);

    assert_hold_between_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(bit_valid) && !$past(rst))
        |-> ($stable(data_o) && $stable(strobe_o)));

    assert_one_line_changes_R4: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> (!active || ((data_o ^ strobe_o) != $past(data_o ^ strobe_o))));

    assert_idle_lines_low_R5: assert property (@(posedge clk) disable iff (rst)
        !active |-> (!data_o && !strobe_o));

    assert_history_cleared_R6: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!hist_d && !hist_s));

    assert_speed_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (!word_load || active) |=> $stable(spd_q));

endmodule

bind ds_tx_encoder ds_tx_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .active    (tx_active),
    .word_load (word_load_o),
    .bit_valid (ser_bit.valid),
    .data_o    (data_o),
    .strobe_o  (strobe_o),
    .spd_q     (spd_q),
    .hist_d    (pair_q.dat),
    .hist_s    (pair_q.stb)
);

// File: tb/ds_tx_encoder_tb.sv
module ds_tx_encoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    // {speed, word, expected data bits MSB-first, expected strobe bits}
    localparam logic [25:0] VEC [0:NV-1] = '{
        {2'b00, 8'h02, 8'h80, 8'h00},
        {2'b00, 8'h00, 8'h00, 8'h80},
        {2'b01, 8'h0C, 8'hC0, 8'h60},
        {2'b01, 8'h05, 8'h50, 8'hF0},
        {2'b10, 8'hA5, 8'hA5, 8'h0F},
        {2'b10, 8'hFF, 8'hFF, 8'h55},
        {2'b10, 8'h00, 8'h00, 8'hAA},
        {2'b11, 8'hFE, 8'h80, 8'h00},
        {2'b01, 8'hF9, 8'h90, 8'h30}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed_i = 2'b00;
    logic       tx_en = 1'b0;
    logic       port_ok = 1'b1;
    logic       pwr_down = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       word_load_o;
    logic       data_o;
    logic       strobe_o;

    int n_chk = 0;
    int n_fail = 0;

    ds_tx_encoder u_dut (
        .clk         (clk),
        .rst         (rst),
        .speed_i     (speed_i),
        .tx_en       (tx_en),
        .port_ok     (port_ok),
        .pwr_down    (pwr_down),
        .tx_data     (tx_data),
        .word_load_o (word_load_o),
        .data_o      (data_o),
        .strobe_o    (strobe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic to_boundary();
        do @(negedge clk); while (!word_load_o);
    endtask

    task automatic collect(input int per, output logic [7:0] gd, output logic [7:0] gs);
        gd = 8'h00;
        gs = 8'h00;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if ((i - 1) % per == 0) begin
                gd[7 - ((i - 1) / per)] = data_o;
                gs[7 - ((i - 1) / per)] = strobe_o;
            end
        end
    endtask

    function automatic int period_of(logic [1:0] s);
        return (s == 2'b10) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    task automatic start_word(input logic [1:0] s, input logic [7:0] w);
        tx_en = 1'b0;
        to_boundary();
        speed_i = s;
        to_boundary();
        tx_en   = 1'b1;
        tx_data = w;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] gd, gs;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 lines in reset", {6'b0, data_o, strobe_o}, 8'h00);
        rst = 1'b0;
        chk("R10 phase restart", {7'b0, word_load_o}, 8'h01);

        // R2: one pulse per eight cycles
        @(negedge clk);
        chk("R2 pulse width", {7'b0, word_load_o}, 8'h00);
        repeat (7) @(negedge clk);
        chk("R2 pulse spacing", {7'b0, word_load_o}, 8'h01);

        // Table walk: R1, R3, R4 per vector
        for (int v = 0; v < NV; v++) begin
            start_word(VEC[v][25:24], VEC[v][23:16]);
            collect(period_of(VEC[v][25:24]), gd, gs);
            tx_en = 1'b0;
            chk($sformatf("R1/R3 data vec%0d", v), gd, VEC[v][15:8]);
            chk($sformatf("R4 strobe vec%0d", v), gs, VEC[v][7:0]);
            #1;
            chk("R5 idle after word", {6'b0, data_o, strobe_o}, 8'h00);
        end

        // R7, R8: back-to-back words, speed change ignored while sending
        start_word(2'b10, 8'hFF);
        collect(1, gd, gs);
        tx_data = 8'h00;
        speed_i = 2'b00;
        chk("R7 first word data", gd, 8'hFF);
        chk("R7 first word strobe", gs, 8'h55);
        collect(1, gd, gs);
        tx_en = 1'b0;
        chk("R8 second word width", gd, 8'h00);
        chk("R7 carried history strobe", gs, 8'hAA);

        // R5: port drop mid-word, then R9: no resume until boundary
        start_word(2'b00, 8'h03);
        repeat (2) @(negedge clk);
        port_ok = 1'b0;
        #1;
        chk("R5 port drop", {6'b0, data_o, strobe_o}, 8'h00);
        @(negedge clk);
        port_ok = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 no resume mid-word", {6'b0, data_o, strobe_o}, 8'h00);

        // R5: power-down mid-word
        start_word(2'b10, 8'hFF);
        repeat (3) @(negedge clk);
        pwr_down = 1'b1;
        #1;
        chk("R5 power down", {6'b0, data_o, strobe_o}, 8'h00);
        @(negedge clk);
        pwr_down = 1'b0;

        // R6: stop after one bit, then history must restart at zero
        start_word(2'b10, 8'h80);
        @(negedge clk);
        chk("R6 single bit sent", {6'b0, data_o, strobe_o}, 8'h02);
        tx_en = 1'b0;
        start_word(2'b00, 8'h03);
        collect(4, gd, gs);
        tx_en = 1'b0;
        chk("R6 data after restart", gd, 8'hC0);
        chk("R6 strobe after restart", gs, 8'h40);

        // R9: enable rises mid-word
        tx_en = 1'b0;
        to_boundary();
        speed_i = 2'b00;
        repeat (3) @(negedge clk);
        tx_en   = 1'b1;
        tx_data = 8'h03;
        repeat (2) @(negedge clk);
        chk("R9 quiet at phase5", {6'b0, data_o, strobe_o}, 8'h00);
        repeat (2) @(negedge clk);
        chk("R9 quiet at phase7", {6'b0, data_o, strobe_o}, 8'h00);
        @(negedge clk);
        chk("R9 boundary reached", {7'b0, word_load_o}, 8'h01);
        @(negedge clk);
        chk("R9 sends after boundary", {6'b0, data_o, strobe_o}, 8'h02);
        tx_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule